// File: doc/BRIEF.md
# Integer Execute Stage

This block is the combinational heart of the execute step in a 32-bit in-order integer pipeline. It takes the register operands, the decoded immediate and the program counter, picks the two operands the arithmetic unit works on, and produces the arithmetic, logic, shift or compare result. In parallel it decides whether a conditional branch or jump redirects the fetch stream and computes where it goes. Pipeline registers, decode, hazard handling and memory access sit around it and are not part of it.

The operation code is a fixed 4-bit field and the condition code a 3-bit field, both supplied by the decoder. Two pass-through operations let an operand reach the result unchanged, which serves upper-immediate loads. Load and store effective addresses use the add operation with the immediate chosen as operand B.

Top module: `exe_stage_unit`

## Requirements
- R1: With `a_from_pc`=0 operand A is `rs1_val`; with 1 it is `pc_val`. Operation code 10 returns operand A unchanged.
- R2: With `b_from_imm`=0 operand B is `rs2_val`; with 1 it is `imm_val`. Operation code 11 returns operand B unchanged.
- R3: Code 0 returns A+B and code 1 returns A-B, both modulo 2^32.
- R4: Code 2 returns A AND B, code 3 A OR B, code 4 A XOR B.
- R5: Code 5 returns 1 when A < B as signed numbers, code 7 when A < B as unsigned numbers, else 0; bits 31..1 of the result are always 0 for these codes.
- R6: Code 6 shifts A left by B[4:0], filling with zeros; bits 31..5 of B have no effect.
- R7: Code 8 shifts A right by B[4:0] filling with zeros; code 9 does the same filling with copies of A[31].
- R8: Codes 12, 13, 14 and 15 return zero.
- R9: With `is_branch`=1, `br_taken` follows the condition on rs1 versus rs2 selected by `br_kind`: 0 equal, 1 not equal, 2 signed greater-or-equal, 3 signed less, 4 unsigned greater-or-equal, 5 unsigned less. The operand selects do not influence the condition.
- R10: With `is_branch`=0 and `is_jump`=0, `br_taken` is 0; `br_kind`=7 is never taken through `is_branch`.
- R11: `is_jump`=1 forces `br_taken`=1; `br_kind`=6 with `is_branch`=1 is also taken.
- R12: With `is_jalr`=0, `br_target` is `pc_val`+`imm_val` modulo 2^32.
- R13: With `is_jalr`=1, `br_target` is `rs1_val`+`imm_val` with bit 0 cleared, independent of `a_from_pc` and `b_from_imm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_val | input | XLEN | First register operand |
| rs2_val | input | XLEN | Second register operand |
| imm_val | input | XLEN | Sign-extended immediate |
| pc_val | input | XLEN | Address of the instruction |
| a_from_pc | input | 1 | Operand A source: 0 rs1, 1 PC |
| b_from_imm | input | 1 | Operand B source: 0 rs2, 1 immediate |
| alu_op | input | 4 | Operation code |
| br_kind | input | 3 | Condition code for branch evaluation |
| is_branch | input | 1 | Instruction is a conditional branch |
| is_jump | input | 1 | Instruction is an unconditional jump |
| is_jalr | input | 1 | Jump target is register based |
| alu_result | output | XLEN | Operation result |
| br_taken | output | 1 | Fetch must be redirected |
| br_target | output | XLEN | Redirect address |

## Verification
The bench builds two copies side by side at XLEN=32: one with the native shift and compare operators, and one with the logarithmic barrel shifter and the subtract-based comparator. Feeding both the same vectors brings the structural variants within reach of the same expectations, so a fault in a single barrel stage or in the borrow-based signed fix-up shows as a divergence on shift amounts and sign-differing operand pairs, which the directed set covers at 0, 1, 31 and with high bits set above the shift field.

// File: rtl/exe_pkg.sv
package exe_pkg;

   typedef enum logic [3:0] {
      OP_ADD    = 4'd0,
      OP_SUB    = 4'd1,
      OP_AND    = 4'd2,
      OP_OR     = 4'd3,
      OP_XOR    = 4'd4,
      OP_SLT    = 4'd5,
      OP_SLL    = 4'd6,
      OP_SLTU   = 4'd7,
      OP_SRL    = 4'd8,
      OP_SRA    = 4'd9,
      OP_PASS_A = 4'd10,
      OP_PASS_B = 4'd11
   } alu_op_e;

   typedef enum logic [2:0] {
      BR_EQ     = 3'd0,
      BR_NE     = 3'd1,
      BR_GE     = 3'd2,
      BR_LT     = 3'd3,
      BR_GEU    = 3'd4,
      BR_LTU    = 3'd5,
      BR_ALWAYS = 3'd6
   } br_kind_e;

   typedef struct packed {
      logic eq;
      logic lt;
      logic ltu;
   } cmp_flags_t;

endpackage

// File: rtl/exe_operand_sel.sv
module exe_operand_sel #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] rs2_val,
   input  logic [XLEN-1:0] imm_val,
   input  logic [XLEN-1:0] pc_val,
   input  logic            a_from_pc,
   input  logic            b_from_imm,
   output logic [XLEN-1:0] op_a,
   output logic [XLEN-1:0] op_b
);
   always_comb begin
      op_a = a_from_pc  ? pc_val  : rs1_val;
      op_b = b_from_imm ? imm_val : rs2_val;
   end
endmodule

// File: rtl/exe_compare.sv
module exe_compare
   import exe_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter bit BY_SUB = 1'b0
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output cmp_flags_t      flags
);
   localparam int MSB = XLEN - 1;

   generate
      if (BY_SUB) begin : g_sub
         logic [XLEN:0] diff;
         always_comb begin
            diff      = {1'b0, a} - {1'b0, b};
            flags.eq  = (diff[MSB:0] == '0);
            flags.ltu = diff[XLEN];
            flags.lt  = (a[MSB] ^ b[MSB]) ? a[MSB] : diff[XLEN];
         end
      end else begin : g_native
         always_comb begin
            flags.eq  = (a == b);
            flags.ltu = (a < b);
            flags.lt  = ($signed(a) < $signed(b));
         end
      end
   endgenerate
endmodule

// File: rtl/exe_shifter.sv
module exe_shifter #(
   parameter int XLEN   = 32,
   parameter bit BARREL = 1'b0,
   localparam int SHW   = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] src,
   input  logic [SHW-1:0]  amt,
   input  logic            dir_left,
   input  logic            arith,
   output logic [XLEN-1:0] dst
);
   generate
      if (BARREL) begin : g_barrel
         logic            fill;
         logic [XLEN-1:0] src_rev;
         logic [XLEN-1:0] stage_in;
         logic [XLEN-1:0] stage_out;
         logic [XLEN-1:0] out_rev;

         always_comb begin
            for (int i = 0; i < XLEN; i++) begin
               src_rev[i] = src[XLEN-1-i];
            end
            fill     = arith & ~dir_left & src[XLEN-1];
            stage_in = dir_left ? src_rev : src;
         end

         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            logic [XLEN-1:0] d;
            logic [XLEN-1:0] q;
            if (s == 0) begin : g_first
               assign d = stage_in;
            end else begin : g_next
               assign d = g_stage[s-1].q;
            end
            assign q = amt[s] ? {{STEP{fill}}, d[XLEN-1:STEP]} : d;
         end

         assign stage_out = g_stage[SHW-1].q;

         always_comb begin
            for (int i = 0; i < XLEN; i++) begin
               out_rev[i] = stage_out[XLEN-1-i];
            end
            dst = dir_left ? out_rev : stage_out;
         end
      end else begin : g_native
         always_comb begin
            if (dir_left)   dst = src << amt;
            else if (arith) dst = $unsigned($signed(src) >>> amt);
            else            dst = src >> amt;
         end
      end
   endgenerate
endmodule

// File: rtl/exe_alu.sv
module exe_alu
   import exe_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit SHIFT_BARREL = 1'b0,
   parameter bit CMP_BY_SUB   = 1'b0,
   localparam int SHW         = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic [3:0]      alu_op,
   output logic [XLEN-1:0] result
);
   cmp_flags_t      flags;
   logic [XLEN-1:0] shifted;
   logic            shl;
   logic            sha;
   logic            unused_eq;
   alu_op_e         op;

   assign op        = alu_op_e'(alu_op);
   assign shl       = (op == OP_SLL);
   assign sha       = (op == OP_SRA);
   assign unused_eq = flags.eq;

   exe_compare #(
      .XLEN  (XLEN),
      .BY_SUB(CMP_BY_SUB)
   ) u_cmp (
      .a    (op_a),
      .b    (op_b),
      .flags(flags)
   );

   exe_shifter #(
      .XLEN  (XLEN),
      .BARREL(SHIFT_BARREL)
   ) u_shift (
      .src     (op_a),
      .amt     (op_b[SHW-1:0]),
      .dir_left(shl),
      .arith   (sha),
      .dst     (shifted)
   );

   always_comb begin
      case (op)
         OP_ADD:    result = op_a + op_b;
         OP_SUB:    result = op_a - op_b;
         OP_AND:    result = op_a & op_b;
         OP_OR:     result = op_a | op_b;
         OP_XOR:    result = op_a ^ op_b;
         OP_SLT:    result = {{(XLEN-1){1'b0}}, flags.lt};
         OP_SLTU:   result = {{(XLEN-1){1'b0}}, flags.ltu};
         OP_SLL,
         OP_SRL,
         OP_SRA:    result = shifted;
         OP_PASS_A: result = op_a;
         OP_PASS_B: result = op_b;
         default:   result = '0;
      endcase
   end
endmodule

// File: rtl/exe_branch_eval.sv
module exe_branch_eval
   import exe_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit CMP_BY_SUB = 1'b0
) (
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] rs2_val,
   input  logic [2:0]      br_kind,
   input  logic            is_branch,
   input  logic            is_jump,
   output logic            br_taken
);
   cmp_flags_t flags;
   logic       cond;

   exe_compare #(
      .XLEN  (XLEN),
      .BY_SUB(CMP_BY_SUB)
   ) u_cmp (
      .a    (rs1_val),
      .b    (rs2_val),
      .flags(flags)
   );

   always_comb begin
      case (br_kind_e'(br_kind))
         BR_EQ:     cond =  flags.eq;
         BR_NE:     cond = ~flags.eq;
         BR_GE:     cond = ~flags.lt;
         BR_LT:     cond =  flags.lt;
         BR_GEU:    cond = ~flags.ltu;
         BR_LTU:    cond =  flags.ltu;
         BR_ALWAYS: cond = 1'b1;
         default:   cond = 1'b0;
      endcase
      br_taken = is_jump | (is_branch & cond);
   end
endmodule

// File: rtl/exe_target_gen.sv
module exe_target_gen #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc_val,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] imm_val,
   input  logic            is_jalr,
   output logic [XLEN-1:0] br_target
);
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] sum;

   always_comb begin
      base      = is_jalr ? rs1_val : pc_val;
      sum       = base + imm_val;
      br_target = {sum[XLEN-1:1], sum[0] & ~is_jalr};
   end
endmodule

// File: rtl/exe_stage_unit.sv
module exe_stage_unit #(
   parameter int XLEN         = 32,
   parameter bit SHIFT_BARREL = 1'b0,
   parameter bit CMP_BY_SUB   = 1'b0
) (
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] rs2_val,
   input  logic [XLEN-1:0] imm_val,
   input  logic [XLEN-1:0] pc_val,
   input  logic            a_from_pc,
   input  logic            b_from_imm,
   input  logic [3:0]      alu_op,
   input  logic [2:0]      br_kind,
   input  logic            is_branch,
   input  logic            is_jump,
   input  logic            is_jalr,
   output logic [XLEN-1:0] alu_result,
   output logic            br_taken,
   output logic [XLEN-1:0] br_target
);
   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("exe_stage_unit: XLEN must be 32 or 64");
      end
   endgenerate

   logic [XLEN-1:0] op_a;
   logic [XLEN-1:0] op_b;

   exe_operand_sel #(.XLEN(XLEN)) u_sel (
      .rs1_val   (rs1_val),
      .rs2_val   (rs2_val),
      .imm_val   (imm_val),
      .pc_val    (pc_val),
      .a_from_pc (a_from_pc),
      .b_from_imm(b_from_imm),
      .op_a      (op_a),
      .op_b      (op_b)
   );

   exe_alu #(
      .XLEN        (XLEN),
      .SHIFT_BARREL(SHIFT_BARREL),
      .CMP_BY_SUB  (CMP_BY_SUB)
   ) u_alu (
      .op_a  (op_a),
      .op_b  (op_b),
      .alu_op(alu_op),
      .result(alu_result)
   );

   exe_branch_eval #(
      .XLEN      (XLEN),
      .CMP_BY_SUB(CMP_BY_SUB)
   ) u_br (
      .rs1_val  (rs1_val),
      .rs2_val  (rs2_val),
      .br_kind  (br_kind),
      .is_branch(is_branch),
      .is_jump  (is_jump),
      .br_taken (br_taken)
   );

   exe_target_gen #(.XLEN(XLEN)) u_tgt (
      .pc_val   (pc_val),
      .rs1_val  (rs1_val),
      .imm_val  (imm_val),
      .is_jalr  (is_jalr),
      .br_target(br_target)
   );
endmodule

// File: rtl/exe_stage_unit_chk.sv
module exe_stage_unit_chk #(
   parameter int XLEN = 32
) (
   input logic [XLEN-1:0] rs1_val,
   input logic [XLEN-1:0] rs2_val,
   input logic [XLEN-1:0] imm_val,
   input logic [XLEN-1:0] pc_val,
   input logic            a_from_pc,
   input logic            b_from_imm,
   input logic [3:0]      alu_op,
   input logic [2:0]      br_kind,
   input logic            is_branch,
   input logic            is_jump,
   input logic            is_jalr,
   input logic [XLEN-1:0] alu_result,
   input logic            br_taken,
   input logic [XLEN-1:0] br_target
);
   always_comb begin
      a_r1_pass_a_pc: assert (!(alu_op == 4'd10 && a_from_pc) || alu_result == pc_val)
         else $error("R1 pass-through of PC broken");
      a_r2_pass_b_imm: assert (!(alu_op == 4'd11 && b_from_imm) || alu_result == imm_val)
         else $error("R2 pass-through of immediate broken");
      a_r5_flag_width: assert (!(alu_op == 4'd5 || alu_op == 4'd7) || alu_result[XLEN-1:1] == '0)
         else $error("R5 compare result wider than one bit");
      a_r8_unused_zero: assert (!(alu_op >= 4'd12) || alu_result == '0)
         else $error("R8 unused code gave nonzero result");
      a_r9_eq_taken: assert (!(is_branch && br_kind == 3'd0 && rs1_val == rs2_val) || br_taken)
         else $error("R9 equal operands not taken");
      a_r10_idle: assert (is_branch || is_jump || !br_taken)
         else $error("R10 taken without branch or jump");
      a_r11_jump: assert (!is_jump || br_taken)
         else $error("R11 jump not taken");
      a_r12_pc_rel: assert (is_jalr || br_target == pc_val + imm_val)
         else $error("R12 PC-relative target wrong");
      a_r13_even: assert (!is_jalr || (br_target[XLEN-1:1] == (rs1_val + imm_val) >> 1 && !br_target[0]))
         else $error("R13 register target wrong");
   end
endmodule

bind exe_stage_unit exe_stage_unit_chk #(.XLEN(XLEN)) u_chk (
   .rs1_val   (rs1_val),
   .rs2_val   (rs2_val),
   .imm_val   (imm_val),
   .pc_val    (pc_val),
   .a_from_pc (a_from_pc),
   .b_from_imm(b_from_imm),
   .alu_op    (alu_op),
   .br_kind   (br_kind),
   .is_branch (is_branch),
   .is_jump   (is_jump),
   .is_jalr   (is_jalr),
   .alu_result(alu_result),
   .br_taken  (br_taken),
   .br_target (br_target)
);

// File: tb/exe_stage_unit_tb_top.sv
module exe_stage_unit_tb_top;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [W-1:0] rs1, rs2, imm, pc;
   logic         asel, bsel, br, jmp, jalr;
   logic [3:0]   op;
   logic [2:0]   kind;
   logic [W-1:0] res0, tgt0, res1, tgt1;
   logic         tk0, tk1;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      string        tag;
      logic [W-1:0] res;
      logic         tk;
      logic [W-1:0] tgt;
   } exp_t;
   exp_t sb_q[$];

   exe_stage_unit #(.XLEN(W)) dut_i (
      .rs1_val(rs1), .rs2_val(rs2), .imm_val(imm), .pc_val(pc),
      .a_from_pc(asel), .b_from_imm(bsel), .alu_op(op), .br_kind(kind),
      .is_branch(br), .is_jump(jmp), .is_jalr(jalr),
      .alu_result(res0), .br_taken(tk0), .br_target(tgt0));

   exe_stage_unit #(.XLEN(W), .SHIFT_BARREL(1'b1), .CMP_BY_SUB(1'b1)) dut_alt_i (
      .rs1_val(rs1), .rs2_val(rs2), .imm_val(imm), .pc_val(pc),
      .a_from_pc(asel), .b_from_imm(bsel), .alu_op(op), .br_kind(kind),
      .is_branch(br), .is_jump(jmp), .is_jalr(jalr),
      .alu_result(res1), .br_taken(tk1), .br_target(tgt1));

   function automatic logic [W-1:0] m_res(logic [3:0] o, logic [W-1:0] a, logic [W-1:0] b);
      logic [4:0] sh = b[4:0];
      case (o)
         4'd0:  return a + b;
         4'd1:  return a - b;
         4'd2:  return a & b;
         4'd3:  return a | b;
         4'd4:  return a ^ b;
         4'd5:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         4'd6:  return a << sh;
         4'd7:  return (a < b) ? 32'd1 : 32'd0;
         4'd8:  return a >> sh;
         4'd9:  return $unsigned($signed(a) >>> sh);
         4'd10: return a;
         4'd11: return b;
         default: return '0;
      endcase
   endfunction

   function automatic logic m_tk(logic [2:0] k, logic b, logic j, logic [W-1:0] x, logic [W-1:0] y);
      logic c;
      case (k)
         3'd0: c = (x == y);
         3'd1: c = (x != y);
         3'd2: c = ($signed(x) >= $signed(y));
         3'd3: c = ($signed(x) < $signed(y));
         3'd4: c = (x >= y);
         3'd5: c = (x < y);
         3'd6: c = 1'b1;
         default: c = 1'b0;
      endcase
      return j | (b & c);
   endfunction

   task automatic drive(string tag, logic [W-1:0] r1, logic [W-1:0] r2, logic [W-1:0] im,
                        logic [W-1:0] p, logic as, logic bs, logic [3:0] o, logic [2:0] k,
                        logic b, logic j, logic jr);
      exp_t e;
      logic [W-1:0] sum;
      @(posedge clk);
      rs1 = r1; rs2 = r2; imm = im; pc = p; asel = as; bsel = bs;
      op = o; kind = k; br = b; jmp = j; jalr = jr;
      e.tag = tag;
      e.res = m_res(o, as ? p : r1, bs ? im : r2);
      e.tk  = m_tk(k, b, j, r1, r2);
      sum   = jr ? r1 + im : p + im;
      e.tgt = jr ? (sum & ~32'd1) : sum;
      sb_q.push_back(e);
   endtask

   task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         chk(e.tag, "result",      res0, e.res);
         chk(e.tag, "taken",       {31'd0, tk0}, {31'd0, e.tk});
         chk(e.tag, "target",      tgt0, e.tgt);
         chk(e.tag, "alt result",  res1, e.res);
         chk(e.tag, "alt taken",   {31'd0, tk1}, {31'd0, e.tk});
         chk(e.tag, "alt target",  tgt1, e.tgt);
      end
   end

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
      end
   end

   initial begin
      rs1 = '0; rs2 = '0; imm = '0; pc = '0; asel = 0; bsel = 0;
      op = '0; kind = '0; br = 0; jmp = 0; jalr = 0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: all-zero inputs
      drive("R10 R12 idle", 0, 0, 0, 0, 0, 0, 4'd0, 3'd0, 0, 0, 0);
      // operand selects
      drive("R1 rs1", 32'h12345678, 32'h1, 32'h2, 32'h40, 0, 0, 4'd10, 3'd7, 0, 0, 0);
      drive("R1 pc",  32'h12345678, 32'h1, 32'h2, 32'h40, 1, 0, 4'd10, 3'd7, 0, 0, 0);
      drive("R2 rs2", 32'h1, 32'hCAFE0000, 32'h5, 32'h40, 0, 0, 4'd11, 3'd7, 0, 0, 0);
      drive("R2 imm lui", 32'h1, 32'hCAFE0000, 32'hABCDE000, 32'h40, 0, 1, 4'd11, 3'd7, 0, 0, 0);
      // add/sub
      drive("R3 add wrap", 32'hFFFFFFFF, 32'h1, 0, 0, 0, 0, 4'd0, 3'd7, 0, 0, 0);
      drive("R3 sub wrap", 32'h0, 32'h1, 0, 0, 0, 0, 4'd1, 3'd7, 0, 0, 0);
      drive("R3 load addr", 32'h1000, 32'h77, 32'hFFFFFFFC, 0, 0, 1, 4'd0, 3'd7, 0, 0, 0);
      drive("R3 auipc", 32'h9, 32'h0, 32'h00002000, 32'h300, 1, 1, 4'd0, 3'd7, 0, 0, 0);
      // logic
      drive("R4 and", 32'hF0F000FF, 32'h0FF0F0F0, 0, 0, 0, 0, 4'd2, 3'd7, 0, 0, 0);
      drive("R4 or",  32'hF0F000FF, 32'h0FF0F0F0, 0, 0, 0, 0, 4'd3, 3'd7, 0, 0, 0);
      drive("R4 xor", 32'hF0F000FF, 32'h0FF0F0F0, 0, 0, 0, 0, 4'd4, 3'd7, 0, 0, 0);
      // compares
      drive("R5 slt neg", 32'h80000000, 32'h1, 0, 0, 0, 0, 4'd5, 3'd7, 0, 0, 0);
      drive("R5 sltu neg", 32'h80000000, 32'h1, 0, 0, 0, 0, 4'd7, 3'd7, 0, 0, 0);
      drive("R5 slt equal", 32'h7, 32'h7, 0, 0, 0, 0, 4'd5, 3'd7, 0, 0, 0);
      drive("R5 sltu less", 32'h3, 32'hFFFFFFFF, 0, 0, 0, 0, 4'd7, 3'd7, 0, 0, 0);
      drive("R5 slt pos vs neg", 32'h3, 32'hFFFFFFFF, 0, 0, 0, 0, 4'd5, 3'd7, 0, 0, 0);
      // shifts
      drive("R6 sll high bits ignored", 32'h1, 32'hFFFFFFE1, 0, 0, 0, 0, 4'd6, 3'd7, 0, 0, 0);
      drive("R6 sll 31", 32'h1, 32'd31, 0, 0, 0, 0, 4'd6, 3'd7, 0, 0, 0);
      drive("R6 sll 0", 32'hA5A5A5A5, 32'h20, 0, 0, 0, 0, 4'd6, 3'd7, 0, 0, 0);
      drive("R7 srl 31", 32'h80000000, 32'd31, 0, 0, 0, 0, 4'd8, 3'd7, 0, 0, 0);
      drive("R7 sra 31", 32'h80000000, 32'd31, 0, 0, 0, 0, 4'd9, 3'd7, 0, 0, 0);
      drive("R7 sra pos", 32'h40000000, 32'd4, 0, 0, 0, 0, 4'd9, 3'd7, 0, 0, 0);
      drive("R7 srai imm", 32'hF0000000, 32'h0, 32'h00000404, 0, 0, 1, 4'd9, 3'd7, 0, 0, 0);
      for (int s = 0; s < 32; s++) begin
         drive("R6 R7 sweep", 32'h9ABCDEF1, s, 0, 0, 0, 0, 4'd6 + 4'(s % 4), 3'd7, 0, 0, 0);
      end
      // unused codes
      for (int c = 12; c < 16; c++) begin
         drive("R8 unused code", 32'hFFFFFFFF, 32'h12345678, 0, 0, 0, 0, 4'(c), 3'd7, 0, 0, 0);
      end
      // branch conditions
      for (int k = 0; k < 6; k++) begin
         drive("R9 equal", 32'h80000005, 32'h80000005, 32'h10, 32'h100, 1, 1, 4'd0, 3'(k), 1, 0, 0);
         drive("R9 sign split", 32'hFFFFFFFF, 32'h1, 32'h10, 32'h100, 0, 0, 4'd0, 3'(k), 1, 0, 0);
         drive("R9 plain less", 32'h2, 32'h9, 32'h10, 32'h100, 0, 0, 4'd0, 3'(k), 1, 0, 0);
      end
      drive("R10 no branch", 32'h4, 32'h4, 32'h8, 32'h200, 0, 0, 4'd0, 3'd0, 0, 0, 0);
      drive("R10 kind 7", 32'h4, 32'h4, 32'h8, 32'h200, 0, 0, 4'd0, 3'd7, 1, 0, 0);
      drive("R11 jump", 32'h4, 32'h5, 32'h8, 32'h200, 1, 0, 4'd0, 3'd6, 0, 1, 0);
      drive("R11 kind 6 branch", 32'h4, 32'h5, 32'h8, 32'h200, 0, 0, 4'd0, 3'd6, 1, 0, 0);
      drive("R12 backward", 32'h0, 32'h0, 32'hFFFFFFF0, 32'h100, 0, 0, 4'd0, 3'd1, 1, 0, 0);
      drive("R13 jalr odd", 32'h2001, 32'h0, 32'h2, 32'h500, 1, 1, 4'd0, 3'd6, 0, 1, 1);
      drive("R13 jalr sel ignored", 32'h2001, 32'h0, 32'h2, 32'h500, 0, 0, 4'd0, 3'd6, 0, 1, 1);
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] x = $urandom;
         drive("R1 R3 R9 R12 random", $urandom, $urandom, $urandom, $urandom,
               x[0], x[1], x[7:4], x[10:8], x[11], x[12], x[13]);
      end
      wait (sb_q.size() == 0);
      repeat (2) @(posedge clk);
      done = 1'b1;
      report();
   end
endmodule